// File: doc/BRIEF.md
# Remote Register Mirroring SPI Master

This block is an SPI master that copies a small set of local output bytes into a remote device's output registers. In the same pass it reads the remote device's input bytes back into local input registers. A pulse on `start` launches one pass. The block snapshots the bytes to be sent, walks a fixed list of transactions and pulses `done` when the list is finished. At that moment every fetched byte appears on the read-side outputs together.

Each transaction moves one byte and costs four single-byte SPI frames. The first frame asks the remote side to stage the input register that pairs with the target output. The second and third frames carry the value as two nibble writes. The remote reply captured during the second frame is the fetched byte. The fourth frame commits the assembled value into the target output register.

A full pass covers two digital bytes and the low and high bytes of two analog words. Clearing `analogEn` cuts the pass down to the two digital transactions. The serial clock is the system clock divided by 32, or by 8 when `divFast` is set. Each frame is followed by a parameterised idle gap, which gives the remote side time to act on the command.

Top module: `spi_mirror_top`

## Requirements
- R1: After reset, `ssN` is high, `sclk` is low, `busy` and `done` are low, and all read-side outputs are zero.
- R2: `start` while idle begins a pass, and the write-side inputs and `divFast` are sampled at that edge, so later changes have no effect on the pass. `start` while busy is ignored: no restart and no second pass.
- R3: Every transaction sends four bytes in this order. First `0x80 | (a<<5) | r`, which fetches the input twin. Second `0x00 | v[7:4]`, the high nibble. Third `0x10 | v[3:0]`, the low nibble. Fourth `0xC0 | (a<<5) | 0x10 | r`, the load. Here a is 1 for analog and 0 for digital, r is the register index and v is the value.
- R4: Transactions run in a fixed order. The first two are digital: `wrDig0` goes to remote output 0 and `wrDig1` to remote output 1, with returns into `rdDig0` and `rdDig1`. The next four are analog with indices 0 to 3: `wrAna0` low byte, `wrAna0` high byte, `wrAna1` low byte, `wrAna1` high byte, with returns into the same bytes of `rdAna0` and `rdAna1`. The returned byte is the one received during the transaction's second frame.
- R5: With `analogEn` low at start, a pass sends only the eight digital bytes. `rdAna0`, `rdAna1` and the remote analog outputs keep their previous values.
- R6: The load command always has bit 4 set and the fetch command always has bit 4 clear, so no remote input register is ever written.
- R7: SPI mode 0, MSB first. `sclk` is low while `ssN` is high. Each half period is DIV/2 system clocks, with DIV being 32 when `divFast` is 0 and 8 when it is 1. `ssN` is low for exactly 8*DIV clocks per byte.
- R8: Between bytes of one pass, `ssN` stays high for GAP_CYCLES to GAP_CYCLES+2 clocks.
- R9: `done` is a one-cycle pulse after the last byte. The read-side outputs change only in that cycle.
- R10: `busy` is high from the edge after an accepted `start` until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch one pass when idle |
| analogEn | input | 1 | Include the four analog transactions |
| divFast | input | 1 | 0: divide by 32, 1: divide by 8 |
| wrDig0 | input | 8 | Digital byte for remote output 0 |
| wrDig1 | input | 8 | Digital byte for remote output 1 |
| wrAna0 | input | 16 | Analog word for remote analog output 0 |
| wrAna1 | input | 16 | Analog word for remote analog output 1 |
| rdDig0 | output | 8 | Fetched remote digital input 0 |
| rdDig1 | output | 8 | Fetched remote digital input 1 |
| rdAna0 | output | 16 | Fetched remote analog input 0 |
| rdAna1 | output | 16 | Fetched remote analog input 1 |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to remote |
| miso | input | 1 | Serial data from remote |
| ssN | output | 1 | Active-low select, one frame per byte |

## Verification
The bench drives a behavioural remote device that decodes every frame, so it catches the following faults at the ports:
- A wrong nibble order or a cleared output bit in the load byte leaves the remote outputs wrong, or shows up as a write to a remote input.
- Capturing the reply in the wrong frame returns the filler byte instead of the staged input.
- A digital-only pass that still runs analog transactions changes the analog mirrors and the byte count.
- Driving a changed input or a second `start` in the middle of a pass shows whether the design leaks new values into a running pass or restarts.
- Sampling the read-side outputs before `done` exposes early or partial updates.

// File: rtl/spi_mirror_pkg.sv
package spi_mirror_pkg;
  localparam int BYTE_W      = 8;
  localparam int NUM_DIG_TXN = 2;
  localparam int NUM_ANA_TXN = 4;
  localparam int NUM_TXN     = NUM_DIG_TXN + NUM_ANA_TXN;
  localparam int TXN_W       = $clog2(NUM_TXN);

  // Frame position inside one transaction
  typedef enum logic [1:0] {STG_FETCH, STG_HI, STG_LO, STG_LOAD} stage_e;

  typedef struct packed {
    logic             snap;
    logic             load;
    logic             capture;
    logic             commit;
    logic [TXN_W-1:0] txn;
    stage_e           stage;
  } strobes_t;

  // Target descriptor {analog, output=1, index[3:0]}
  function automatic logic [5:0] targetDesc(input logic [TXN_W-1:0] txn);
    logic       isAna;
    logic [3:0] idx;
    isAna = (txn >= TXN_W'(NUM_DIG_TXN));
    idx   = isAna ? 4'(txn - TXN_W'(NUM_DIG_TXN)) : 4'(txn);
    return {isAna, 1'b1, idx};
  endfunction

  function automatic logic [7:0] cmdByte(input stage_e stg, input logic [5:0] desc,
                                         input logic [7:0] val);
    logic [7:0] b;
    case (stg)
      STG_FETCH: b = {2'b10, desc[5], 1'b0, desc[3:0]};
      STG_HI:    b = {4'b0000, val[7:4]};
      STG_LO:    b = {4'b0001, val[3:0]};
      default:   b = {2'b11, desc};
    endcase
    return b;
  endfunction
endpackage

// File: rtl/spi_mirror_ctrl.sv
module spi_mirror_ctrl
  import spi_mirror_pkg::*;
#(
  parameter int GAP_CYCLES = 240
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     analogEn,
  input  logic     byteDone,
  output strobes_t ctl,
  output logic     busy,
  output logic     done
);
  localparam int GAP_W = $clog2(GAP_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_XFER, S_GAP} state_e;

  state_e           state;
  logic [TXN_W-1:0] txn;
  logic [TXN_W-1:0] lastTxn;
  stage_e           stage;
  logic [GAP_W-1:0] gapCnt;
  logic             lastByte;

  assign lastByte = (stage == STG_LOAD) && (txn == lastTxn);
  assign busy     = (state != S_IDLE);

  always_comb begin
    ctl.snap    = (state == S_IDLE) && start;
    ctl.load    = (state == S_LOAD);
    ctl.capture = (state == S_XFER) && byteDone && (stage == STG_HI);
    ctl.commit  = (state == S_XFER) && byteDone && lastByte;
    ctl.txn     = txn;
    ctl.stage   = stage;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      txn     <= '0;
      lastTxn <= '0;
      stage   <= STG_FETCH;
      gapCnt  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          txn     <= '0;
          stage   <= STG_FETCH;
          lastTxn <= analogEn ? TXN_W'(NUM_TXN - 1) : TXN_W'(NUM_DIG_TXN - 1);
          state   <= S_LOAD;
        end
        S_LOAD: state <= S_XFER;
        S_XFER: if (byteDone) begin
          if (lastByte) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            gapCnt <= '0;
            state  <= S_GAP;
            if (stage == STG_LOAD) begin
              stage <= STG_FETCH;
              txn   <= txn + 1'b1;
            end else begin
              stage <= stage_e'(stage + 2'd1);
            end
          end
        end
        default: begin
          if (gapCnt == GAP_W'(GAP_CYCLES - 1)) state <= S_LOAD;
          else gapCnt <= gapCnt + 1'b1;
        end
      endcase
    end
  end

  // R9: end-of-pass pulse lasts one cycle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5: the transaction index never passes the end chosen at start
  assert_txn_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (txn <= lastTxn));

  // R2: a start seen while busy does not end the pass early
  assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !ctl.commit) |=> busy);
endmodule

// File: rtl/spi_mirror_dp.sv
module spi_mirror_dp
  import spi_mirror_pkg::*;
#(
  parameter int DIV_SLOW = 32,
  parameter int DIV_FAST = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobes_t              ctl,
  input  logic                  divFast,
  input  logic [BYTE_W-1:0]     wrDig0,
  input  logic [BYTE_W-1:0]     wrDig1,
  input  logic [2*BYTE_W-1:0]   wrAna0,
  input  logic [2*BYTE_W-1:0]   wrAna1,
  input  logic                  miso,
  output logic                  byteDone,
  output logic                  sclk,
  output logic                  mosi,
  output logic                  ssN,
  output logic [BYTE_W-1:0]     rdDig0,
  output logic [BYTE_W-1:0]     rdDig1,
  output logic [2*BYTE_W-1:0]   rdAna0,
  output logic [2*BYTE_W-1:0]   rdAna1
);
  localparam int HALF_SLOW = DIV_SLOW / 2;
  localparam int HALF_FAST = DIV_FAST / 2;
  localparam int HALF_MAX  = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
  localparam int CNT_W     = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1;
  localparam int EDGES     = 2 * BYTE_W;

  logic [BYTE_W-1:0]         liveVal [NUM_TXN];
  logic [BYTE_W-1:0]         snapVal [NUM_TXN];
  logic [BYTE_W-1:0]         retBuf  [NUM_TXN];
  logic [BYTE_W-1:0]         retOut  [NUM_TXN];
  logic [NUM_TXN*BYTE_W-1:0] retFlat;
  logic                      fastSel;
  logic [CNT_W-1:0]          divCnt;
  logic [CNT_W-1:0]          halfLim;
  logic [$clog2(EDGES)-1:0]  edgeCnt;
  logic [BYTE_W-1:0]         shReg;
  logic [BYTE_W-1:0]         rxReg;
  logic [BYTE_W-1:0]         txByte;

  // Transaction order: two digital bytes, then analog low/high per word
  always_comb begin
    liveVal[0] = wrDig0;
    liveVal[1] = wrDig1;
    liveVal[2] = wrAna0[BYTE_W-1:0];
    liveVal[3] = wrAna0[2*BYTE_W-1:BYTE_W];
    liveVal[4] = wrAna1[BYTE_W-1:0];
    liveVal[5] = wrAna1[2*BYTE_W-1:BYTE_W];
  end

  assign txByte  = cmdByte(ctl.stage, targetDesc(ctl.txn), snapVal[ctl.txn]);
  assign halfLim = fastSel ? CNT_W'(HALF_FAST - 1) : CNT_W'(HALF_SLOW - 1);
  assign mosi    = shReg[BYTE_W-1];

  // Snapshot, return capture and coherent commit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fastSel <= 1'b0;
      for (int i = 0; i < NUM_TXN; i++) begin
        snapVal[i] <= '0;
        retBuf[i]  <= '0;
        retOut[i]  <= '0;
      end
    end else begin
      if (ctl.snap) begin
        fastSel <= divFast;
        for (int i = 0; i < NUM_TXN; i++) snapVal[i] <= liveVal[i];
      end
      if (ctl.capture) retBuf[ctl.txn] <= rxReg;
      if (ctl.commit) begin
        for (int i = 0; i < NUM_TXN; i++) retOut[i] <= retBuf[i];
      end
    end
  end

  // Byte shifter: mode 0, MSB first, one select frame per byte
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ssN      <= 1'b1;
      sclk     <= 1'b0;
      shReg    <= '0;
      rxReg    <= '0;
      divCnt   <= '0;
      edgeCnt  <= '0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (ctl.load) begin
        ssN     <= 1'b0;
        sclk    <= 1'b0;
        shReg   <= txByte;
        divCnt  <= '0;
        edgeCnt <= '0;
      end else if (!ssN) begin
        if (divCnt == halfLim) begin
          divCnt  <= '0;
          sclk    <= !sclk;
          edgeCnt <= edgeCnt + 1'b1;
          if (!sclk) rxReg <= {rxReg[BYTE_W-2:0], miso};
          else       shReg <= {shReg[BYTE_W-2:0], 1'b0};
          if (edgeCnt == $clog2(EDGES)'(EDGES - 1)) begin
            ssN      <= 1'b1;
            byteDone <= 1'b1;
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_TXN; g++) begin : g_flat
    assign retFlat[g*BYTE_W +: BYTE_W] = retOut[g];
  end

  assign rdDig0 = retOut[0];
  assign rdDig1 = retOut[1];
  assign rdAna0 = {retOut[3], retOut[2]};
  assign rdAna1 = {retOut[5], retOut[4]};

  // R7: clock parks low whenever the select is released
  assert_idle_clock_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    ssN |-> !sclk);

  // R7: data is already settled when the clock rises
  assert_mosi_setup_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |-> $stable(mosi));

  // R9: read-side registers move only on the commit strobe
  assert_commit_only_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.commit |=> $stable(retFlat));

  // R8: a new frame is only launched from an idle select
  assert_load_when_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |-> (ssN && !byteDone));
endmodule

// File: rtl/spi_mirror_top.sv
module spi_mirror_top
  import spi_mirror_pkg::*;
#(
  parameter int GAP_CYCLES = 240,
  parameter int DIV_SLOW   = 32,
  parameter int DIV_FAST   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                analogEn,
  input  logic                divFast,
  input  logic [BYTE_W-1:0]   wrDig0,
  input  logic [BYTE_W-1:0]   wrDig1,
  input  logic [2*BYTE_W-1:0] wrAna0,
  input  logic [2*BYTE_W-1:0] wrAna1,
  output logic [BYTE_W-1:0]   rdDig0,
  output logic [BYTE_W-1:0]   rdDig1,
  output logic [2*BYTE_W-1:0] rdAna0,
  output logic [2*BYTE_W-1:0] rdAna1,
  output logic                busy,
  output logic                done,
  output logic                sclk,
  output logic                mosi,
  input  logic                miso,
  output logic                ssN
);
  strobes_t ctl;
  logic     byteDone;

  spi_mirror_ctrl #(.GAP_CYCLES(GAP_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .analogEn(analogEn),
    .byteDone(byteDone), .ctl(ctl), .busy(busy), .done(done)
  );

  spi_mirror_dp #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .divFast(divFast),
    .wrDig0(wrDig0), .wrDig1(wrDig1), .wrAna0(wrAna0), .wrAna1(wrAna1),
    .miso(miso), .byteDone(byteDone), .sclk(sclk), .mosi(mosi), .ssN(ssN),
    .rdDig0(rdDig0), .rdDig1(rdDig1), .rdAna0(rdAna0), .rdAna1(rdAna1)
  );
endmodule

// File: tb/tb_spi_mirror_top.sv
`timescale 1ns/1ps
module tb_spi_mirror_top;
  localparam int GAP = 240;
  localparam int DS  = 32;
  localparam int DF  = 8;

  typedef struct packed {
    logic ana; logic fast;
    logic [7:0] d0; logic [7:0] d1; logic [15:0] a0; logic [15:0] a1;
    logic [7:0] si0; logic [7:0] si1; logic [15:0] sa0; logic [15:0] sa1;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{1'b1, 1'b0, 8'h3C, 8'hA5, 16'h1234, 16'hBEEF, 8'h81, 8'h02, 16'h5566, 16'hC3F0},
    '{1'b1, 1'b1, 8'hFF, 8'h00, 16'hFFFF, 16'h0001, 8'h00, 8'hFF, 16'h8001, 16'h7FFE},
    '{1'b0, 1'b0, 8'h55, 8'hAA, 16'hDEAD, 16'hCAFE, 8'hF0, 8'h0F, 16'h1111, 16'h2222},
    '{1'b0, 1'b1, 8'h01, 8'h80, 16'h0000, 16'h0000, 8'h7E, 8'hE7, 16'h3333, 16'h4444}
  };

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, analogEn = 1'b0, divFast = 1'b0;
  logic [7:0]  wrDig0 = '0, wrDig1 = '0;
  logic [15:0] wrAna0 = '0, wrAna1 = '0;
  logic [7:0]  rdDig0, rdDig1;
  logic [15:0] rdAna0, rdAna1;
  logic busy, done, sclk, mosi, ssN;
  logic miso = 1'b0;

  always #2.5 clk = ~clk;

  spi_mirror_top #(.GAP_CYCLES(GAP), .DIV_SLOW(DS), .DIV_FAST(DF)) dut (
    .clk(clk), .rstN(rstN), .start(start), .analogEn(analogEn), .divFast(divFast),
    .wrDig0(wrDig0), .wrDig1(wrDig1), .wrAna0(wrAna0), .wrAna1(wrAna1),
    .rdDig0(rdDig0), .rdDig1(rdDig1), .rdAna0(rdAna0), .rdAna1(rdAna1),
    .busy(busy), .done(done), .sclk(sclk), .mosi(mosi), .miso(miso), .ssN(ssN)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural remote device and line monitor
  logic [7:0] sDi [2], sDo [2], sAi [4], sAo [4];
  logic [7:0] datr = '0, nextReply = 8'h5A, curReply = '0, rx = '0;
  logic [7:0] logB [32];
  logic prevSs = 1'b1, prevSclk = 1'b0;
  bit   seenByte = 0;
  int   nBytes = 0, inWrites = 0, halfCnt = 0, lowCnt = 0, gapCnt = 0;
  int   halfMin, halfMax, lowMin, lowMax, gapMin, gapMax;

  initial begin
    for (int i = 0; i < 2; i++) begin sDi[i] = '0; sDo[i] = '0; end
    for (int i = 0; i < 4; i++) begin sAi[i] = '0; sAo[i] = '0; end
  end

  always @(negedge clk) begin
    if (!ssN) lowCnt++;
    if (busy && ssN && seenByte) gapCnt++;
    if (prevSs && !ssN) begin
      curReply  = nextReply;
      nextReply = 8'h5A;
      miso      = curReply[7];
      halfCnt   = 0;
      if (seenByte) begin
        if (gapCnt < gapMin) gapMin = gapCnt;
        if (gapCnt > gapMax) gapMax = gapCnt;
      end
    end else if (!ssN) begin
      halfCnt++;
      if (sclk != prevSclk) begin
        if (halfCnt < halfMin) halfMin = halfCnt;
        if (halfCnt > halfMax) halfMax = halfCnt;
        halfCnt = 0;
        if (sclk) rx = {rx[6:0], mosi};
        else begin
          curReply = {curReply[6:0], 1'b0};
          miso     = curReply[7];
        end
      end
    end
    if (!prevSs && ssN) begin
      case (rx[7:6])
        2'b10: nextReply = rx[5] ? (rx[4] ? sAo[rx[1:0]] : sAi[rx[1:0]])
                                 : (rx[4] ? sDo[rx[0]]   : sDi[rx[0]]);
        2'b00: if (!rx[5]) begin
                 if (rx[4]) datr[3:0] = rx[3:0];
                 else       datr[7:4] = rx[3:0];
               end
        2'b11: if (!rx[4]) inWrites++;
               else if (rx[5]) sAo[rx[1:0]] = datr;
               else            sDo[rx[0]]   = datr;
        default: ;
      endcase
      if (nBytes < 32) logB[nBytes] = rx;
      nBytes++;
      if (lowCnt < lowMin) lowMin = lowCnt;
      if (lowCnt > lowMax) lowMax = lowCnt;
      lowCnt   = 0;
      gapCnt   = 0;
      seenByte = 1;
    end
    prevSs   = ssN;
    prevSclk = sclk;
  end

  task automatic resetMon();
    nBytes = 0; inWrites = 0; seenByte = 0;
    halfMin = 1000000; halfMax = 0; lowMin = 1000000; lowMax = 0;
    gapMin = 1000000; gapMax = 0;
  endtask

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic waitDone();
    int n;
    n = 0;
    while (!done && n < 40000) begin @(negedge clk); n++; end
    chk(done === 1'b1, "R9 pass finishes with done", {31'd0, done}, 32'd1);
  endtask

  // Expected command byte for transaction t, frame s
  function automatic logic [7:0] expByte(input int t, input int s, input vec_t v);
    logic a; logic [3:0] r; logic [7:0] val;
    a = (t >= 2);
    r = (t < 2) ? 4'(t) : 4'(t - 2);
    case (t)
      0: val = v.d0;        1: val = v.d1;
      2: val = v.a0[7:0];   3: val = v.a0[15:8];
      4: val = v.a1[7:0];   default: val = v.a1[15:8];
    endcase
    case (s)
      0: return {2'b10, a, 1'b0, r};
      1: return {4'h0, val[7:4]};
      2: return {4'h1, val[3:0]};
      default: return {2'b11, a, 1'b1, r};
    endcase
  endfunction

  initial begin
    #750000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [15:0] expRdAna0 = '0, expRdAna1 = '0;
  logic [7:0]  expSAo [4];

  initial begin
    vec_t v;
    int   nExp, bad, half;
    for (int i = 0; i < 4; i++) expSAo[i] = '0;
    resetMon();
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(ssN === 1'b1 && sclk === 1'b0, "R1 lines idle", {30'd0, ssN, sclk}, 32'h2);
    chk(busy === 1'b0 && done === 1'b0, "R1 busy/done low", {30'd0, busy, done}, 32'h0);
    chk({rdDig0, rdDig1, rdAna0} === 32'h0 && rdAna1 === 16'h0, "R1 reads zero",
        {rdDig0, rdDig1, rdAna0}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // Table of passes
    for (int i = 0; i < 4; i++) begin
      v = VECS[i];
      sDi[0] = v.si0; sDi[1] = v.si1;
      sAi[0] = v.sa0[7:0]; sAi[1] = v.sa0[15:8]; sAi[2] = v.sa1[7:0]; sAi[3] = v.sa1[15:8];
      wrDig0 = v.d0; wrDig1 = v.d1; wrAna0 = v.a0; wrAna1 = v.a1;
      analogEn = v.ana; divFast = v.fast;
      resetMon();
      pulseStart();
      waitDone();
      nExp = v.ana ? 24 : 8;
      chk(nBytes == nExp, "R5 bytes per pass", nBytes, nExp);
      bad = 0;
      for (int t = 0; t < nExp / 4; t++)
        for (int s = 0; s < 4; s++)
          if (logB[t*4+s] !== expByte(t, s, v)) bad++;
      chk(bad == 0, "R3 R4 command sequence", bad, 0);
      chk(rdDig0 === v.si0 && rdDig1 === v.si1, "R4 digital returns", {rdDig0, rdDig1}, {v.si0, v.si1});
      if (v.ana) begin
        expRdAna0 = v.sa0; expRdAna1 = v.sa1;
        expSAo[0] = v.a0[7:0]; expSAo[1] = v.a0[15:8]; expSAo[2] = v.a1[7:0]; expSAo[3] = v.a1[15:8];
      end
      chk(rdAna0 === expRdAna0 && rdAna1 === expRdAna1, "R5 analog returns",
          {rdAna0, rdAna1}, {expRdAna0, expRdAna1});
      chk(sDo[0] === v.d0 && sDo[1] === v.d1, "R3 remote digital outputs", {sDo[0], sDo[1]}, {v.d0, v.d1});
      chk({sAo[0], sAo[1], sAo[2], sAo[3]} === {expSAo[0], expSAo[1], expSAo[2], expSAo[3]},
          "R5 remote analog outputs", {sAo[0], sAo[1], sAo[2], sAo[3]},
          {expSAo[0], expSAo[1], expSAo[2], expSAo[3]});
      chk(inWrites == 0, "R6 no remote input written", inWrites, 0);
      half = v.fast ? DF / 2 : DS / 2;
      chk(halfMin == half && halfMax == half, "R7 half period", {halfMin[15:0], halfMax[15:0]}, {half[15:0], half[15:0]});
      chk(lowMin == 16 * half && lowMax == 16 * half, "R7 select low per byte", lowMax, 16 * half);
      chk(gapMin >= GAP && gapMax <= GAP + 2, "R8 inter-byte gap", {gapMin[15:0], gapMax[15:0]}, GAP);
      @(negedge clk);
      chk(done === 1'b0, "R9 done one cycle", {31'd0, done}, 32'd0);
      chk(busy === 1'b0, "R10 busy clears", {31'd0, busy}, 32'd0);
    end

    // Mid-pass changes: snapshot, ignored start, no early return update
    sDi[0] = 8'h99; wrDig0 = 8'h11; analogEn = 1'b1; divFast = 1'b0;
    resetMon();
    pulseStart();
    chk(busy === 1'b1, "R10 busy after start", {31'd0, busy}, 32'd1);
    repeat (2000) @(negedge clk);
    chk(rdDig0 === 8'h7E, "R9 no update before done", rdDig0, 8'h7E);
    wrDig0 = 8'h22;
    pulseStart();
    waitDone();
    chk(sDo[0] === 8'h11, "R2 value sampled at start", sDo[0], 8'h11);
    chk(nBytes == 24, "R2 start while busy ignored", nBytes, 24);
    chk(rdDig0 === 8'h99, "R4 new digital return", rdDig0, 8'h99);
    repeat (800) @(negedge clk);
    chk(nBytes == 24 && ssN === 1'b1, "R2 no second pass", nBytes, 24);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule